// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Operating Modes

This block multiplies two register operands and adds the product to, or subtracts it from, a 32-bit accumulator. The product passes through three pipeline stages: operand capture, multiply and scale, then accumulate. An issue handshake (`issue_valid` / `issue_ready`) admits operations. The gap before the next operation can be accepted depends on the operand width and on the arithmetic mode. Half-width (16-bit) operations issue every cycle. Full-width (32-bit) integer operations issue every third cycle. Full-width fractional operations issue every fourth cycle.

An 8-bit status byte holds four mode bits and three condition flags. The mode bits select signed or unsigned operands, integer or fractional scaling, saturating or wrapping overflow, and rounding or truncation. The flags report negative, zero and a sticky overflow. Software reads and writes both the accumulator and the status byte through a single-register port (`reg_wr`, `reg_sel`, `reg_wdata`, `reg_rdata`). The issue controller is a two-state machine:
- `ISS_OPEN` (ready) moves to `ISS_HOLD` when it accepts an operation whose interval is longer than one cycle, and stays in `ISS_OPEN` otherwise.
- `ISS_HOLD` (not ready) counts down and returns to `ISS_OPEN` when the count expires.

Top module: `mac_unit`

## Requirements
- R1: After reset the status byte reads 0x00 (wrapping, unsigned, integer, truncating, all flags clear) and `issue_ready` is high.
- R2: After accepting an operation, `issue_ready` stays high for a half-width operation. It goes low for 2 cycles after a full-width integer operation and for 3 cycles after a full-width fractional operation (mode bit 5 set when the operation is accepted).
- R3: An operation accepted at clock edge e changes the accumulator at edge e+2. Half-width operations issued on consecutive cycles all accumulate correctly.
- R4: Status bit 6 = 1 treats the operands as two's complement; bit 6 = 0 treats them as unsigned. With `op_long` = 0 only bits 15:0 of each source are used.
- R5: Status bit 5 = 1 selects signed Q-format operands whose product is doubled. For full-width operands the low 32 bits of the doubled product are discarded; a half-width product is kept whole.
- R6: With bit 5 set, status bit 4 = 1 adds 2^31 to the doubled full-width product before the low 32 bits are dropped. Bit 4 = 0 truncates.
- R7: Status bit 7 = 1 clamps an out-of-range result. For signed results the limits are 0x7FFFFFFF and 0x80000000; for unsigned results they are 0xFFFFFFFF and 0x00000000.
- R8: With bit 7 = 0 an out-of-range result wraps to its low 32 bits. Either way overflow sets V (bit 1), and V stays set through later operations until the status byte is written.
- R9: After each operation, N (bit 3) equals bit 31 of the new accumulator and Z (bit 2) is set exactly when it is zero.
- R10: Writing the status byte (`reg_sel` = 0) loads bits 7:1 from `reg_wdata`. Bit 0 and bits 31:8 always read zero.
- R11: With `op_sub` = 1 the product is subtracted from the accumulator, with the same overflow, saturation and flag rules.
- R12: Writing with `reg_sel` = 1 loads the accumulator, and `reg_rdata` returns it while `reg_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Operation offered |
| issue_ready | output | 1 | Operation can be accepted this cycle |
| op_long | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| op_sub | input | 1 | 1 = subtract product, 0 = add |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status byte, 1 = accumulator |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |

## Verification
The bench targets several corner cases, each tied to a specific failure it would expose:
- **Issue gap.** A one-off error in the issue counter shows up as `issue_ready` rising a cycle early or late after full-width operations.
- **Accumulate forwarding.** Back-to-back half-width operations catch a pipeline that reads a stale accumulator and loses a product.
- **Fractional scaling.** The tiny full-width product 1 × 0x40000000 gives 0 when truncated and 1 when rounded, which exposes a missing doubling or a misplaced rounding constant.
- **Saturation and flags.** Clamping is tested at both signed limits and at unsigned zero after a subtraction. A wrapped result followed by a clean operation shows whether V is sticky or is wrongly recomputed on every operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Mode nibble, occupies status bits 7..4 in this order.
    typedef struct packed {
        logic sat;   // 1 = clamp on overflow
        logic sgn;   // 1 = two's complement operands
        logic frac;  // 1 = Q-format operands
        logic rnd;   // 1 = round discarded half
    } mode_t;

    // Condition flags, occupy status bits 3..1 in this order.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
    } flags_t;

    typedef enum logic [0:0] {
        ISS_OPEN = 1'b0,
        ISS_HOLD = 1'b1
    } iss_state_t;

    localparam int STAT_W = 8;

endpackage

// File: rtl/mac_issue_ctl.sv
module mac_issue_ctl
    import mac_pkg::*;
#(
    parameter int WORD_II  = 1,
    parameter int LINT_II  = 3,
    parameter int LFRAC_II = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_valid,
    input  logic op_long,
    input  logic frac_mode,
    output logic issue_ready,
    output logic accept
);

    localparam int MAX_II = (LFRAC_II > LINT_II) ?
                            ((LFRAC_II > WORD_II) ? LFRAC_II : WORD_II) :
                            ((LINT_II > WORD_II) ? LINT_II : WORD_II);
    localparam int CW = $clog2(MAX_II) + 1;

    iss_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    int            interval;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ISS_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        interval = op_long ? (frac_mode ? LFRAC_II : LINT_II) : WORD_II;
        unique case (state_q)
            ISS_OPEN: begin
                if (issue_valid && interval > 1) begin
                    state_d = ISS_HOLD;
                    cnt_d   = CW'(interval - 2);
                end
            end
            ISS_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = ISS_OPEN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ISS_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        issue_ready = (state_q == ISS_OPEN);
        accept      = issue_valid && (state_q == ISS_OPEN);
    end

endmodule

// File: rtl/mac_mul_pipe.sv
module mac_mul_pipe
    import mac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept,
    input  logic                       op_long,
    input  logic                       op_sub,
    input  logic [DATA_W-1:0]          src_a,
    input  logic [DATA_W-1:0]          src_b,
    input  mode_t                      mode,
    output logic                       p_valid,
    output logic                       p_sub,
    output logic                       p_signed,
    output logic                       p_sat,
    output logic signed [2*DATA_W+3:0] p_term
);

    localparam int HALF_W = DATA_W / 2;
    localparam int OPW    = DATA_W + 1;
    localparam int PRW    = 2 * OPW;
    localparam int PW     = 2 * DATA_W + 4;

    function automatic logic signed [OPW-1:0] widen(
        input logic [DATA_W-1:0] v, input logic lng, input logic sx);
        if (lng) widen = {sx & v[DATA_W-1], v};
        else     widen = {{(OPW-HALF_W){sx & v[HALF_W-1]}}, v[HALF_W-1:0]};
    endfunction

    // Stage 1: operand capture
    logic                  s1_valid, s1_sub, s1_long, s1_frac, s1_rnd, s1_sat, s1_signed;
    logic signed [OPW-1:0] s1_a, s1_b;
    logic                  ext_signed;

    assign ext_signed = mode.sgn | mode.frac;

    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= accept;
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            s1_a      <= widen(src_a, op_long, ext_signed);
            s1_b      <= widen(src_b, op_long, ext_signed);
            s1_sub    <= op_sub;
            s1_long   <= op_long;
            s1_frac   <= mode.frac;
            s1_rnd    <= mode.rnd;
            s1_sat    <= mode.sat;
            s1_signed <= ext_signed;
        end
    end

    // Stage 2: multiply and fractional scaling
    logic signed [PRW-1:0] prod;
    logic signed [PW-1:0]  prod_w, dbl, rnd_add, term;

    always_comb begin
        prod    = s1_a * s1_b;
        prod_w  = {{(PW-PRW){prod[PRW-1]}}, prod};
        dbl     = prod_w <<< 1;
        rnd_add = '0;
        rnd_add[DATA_W-1] = s1_rnd & s1_long;
        if (!s1_frac)     term = prod_w;
        else if (s1_long) term = (dbl + rnd_add) >>> DATA_W;
        else              term = dbl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_valid <= 1'b0;
        else        p_valid <= s1_valid;
    end

    always_ff @(posedge clk) begin
        if (s1_valid) begin
            p_term   <= term;
            p_sub    <= s1_sub;
            p_signed <= s1_signed;
            p_sat    <= s1_sat;
        end
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       p_valid,
    input  logic                       p_sub,
    input  logic                       p_signed,
    input  logic                       p_sat,
    input  logic signed [2*DATA_W+3:0] p_term,
    input  logic                       reg_wr,
    input  logic                       reg_sel,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          acc_q,
    output mode_t                      mode_q,
    output flags_t                     flags_q
);

    localparam int PW = 2 * DATA_W + 4;
    localparam logic signed [PW-1:0] LO_S = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [PW-1:0] HI_S = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PW-1:0] HI_U = {{(PW-DATA_W){1'b0}}, {DATA_W{1'b1}}};

    logic signed [PW-1:0] acc_w, sum, lo, hi;
    logic                 ovf_lo, ovf_hi;
    logic [DATA_W-1:0]    res;

    // Stage 3: accumulate with range check
    always_comb begin
        acc_w  = p_signed ? {{(PW-DATA_W){acc_q[DATA_W-1]}}, acc_q}
                          : {{(PW-DATA_W){1'b0}}, acc_q};
        sum    = p_sub ? (acc_w - p_term) : (acc_w + p_term);
        lo     = p_signed ? LO_S : '0;
        hi     = p_signed ? HI_S : HI_U;
        ovf_lo = (sum < lo);
        ovf_hi = (sum > hi);
        if (p_sat && ovf_lo)
            res = p_signed ? {1'b1, {(DATA_W-1){1'b0}}} : '0;
        else if (p_sat && ovf_hi)
            res = p_signed ? {1'b0, {(DATA_W-1){1'b1}}} : '1;
        else
            res = sum[DATA_W-1:0];
    end

    // Accumulator has no reset value; a register write wins over a retiring result.
    always_ff @(posedge clk) begin
        if (reg_wr && reg_sel) acc_q <= reg_wdata;
        else if (p_valid)      acc_q <= res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            flags_q <= '0;
        end else if (reg_wr && !reg_sel) begin
            mode_q  <= mode_t'(reg_wdata[7:4]);
            flags_q <= flags_t'(reg_wdata[3:1]);
        end else if (p_valid) begin
            flags_q.n <= res[DATA_W-1];
            flags_q.z <= (res == '0);
            flags_q.v <= flags_q.v | ovf_lo | ovf_hi;
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int WORD_II  = 1,
    parameter int LINT_II  = 3,
    parameter int LFRAC_II = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic              op_long,
    input  logic              op_sub,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int PW = 2 * DATA_W + 4;

    logic                 accept, retire, p_sub, p_signed, p_sat;
    logic signed [PW-1:0] p_term;
    logic [DATA_W-1:0]    acc_q;
    mode_t                mode_q;
    flags_t               flags_q;
    logic [STAT_W-1:0]    stat_byte;

    mac_issue_ctl #(
        .WORD_II (WORD_II),
        .LINT_II (LINT_II),
        .LFRAC_II(LFRAC_II)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_valid(issue_valid),
        .op_long    (op_long),
        .frac_mode  (mode_q.frac),
        .issue_ready(issue_ready),
        .accept     (accept)
    );

    mac_mul_pipe #(.DATA_W(DATA_W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .op_long (op_long),
        .op_sub  (op_sub),
        .src_a   (src_a),
        .src_b   (src_b),
        .mode    (mode_q),
        .p_valid (retire),
        .p_sub   (p_sub),
        .p_signed(p_signed),
        .p_sat   (p_sat),
        .p_term  (p_term)
    );

    mac_accum #(.DATA_W(DATA_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .p_valid  (retire),
        .p_sub    (p_sub),
        .p_signed (p_signed),
        .p_sat    (p_sat),
        .p_term   (p_term),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .acc_q    (acc_q),
        .mode_q   (mode_q),
        .flags_q  (flags_q)
    );

    assign stat_byte = {mode_q, flags_q, 1'b0};
    assign reg_rdata = reg_sel ? acc_q : {{(DATA_W-STAT_W){1'b0}}, stat_byte};

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic              issue_ready,
    input logic              op_long,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [7:0]        wr_low,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [7:0]        stat_byte,
    input logic [DATA_W-1:0] acc_q,
    input logic              retire
);

    assert_word_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready && !op_long) |=> issue_ready);

    assert_long_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready && op_long) |=> !issue_ready ##1 !issue_ready);

    assert_frac_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready && op_long && stat_byte[5])
            |=> !issue_ready ##1 !issue_ready ##1 !issue_ready);

    assert_v_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte[1] && !(reg_wr && !reg_sel)) |=> stat_byte[1]);

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !reg_wr) |=> (stat_byte[2] == (acc_q == '0)));

    assert_status_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |=> (stat_byte == {$past(wr_low[7:1]), 1'b0}));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[DATA_W-1:8] == '0 && reg_rdata[0] == 1'b0));

endmodule

bind mac_unit mac_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .issue_ready(issue_ready),
    .op_long    (op_long),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .wr_low     (reg_wdata[7:0]),
    .reg_rdata  (reg_rdata),
    .stat_byte  (stat_byte),
    .acc_q      (acc_q),
    .retire     (retire)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid, op_long, op_sub, reg_wr;
    logic [31:0] src_a, src_b, reg_wdata;
    logic        issue_ready, reg_sel;
    logic [31:0] reg_rdata;
    logic        tog, bforce, bsel;

    always #10 clk = ~clk;   // 50 MHz

    assign reg_sel = bforce ? bsel : tog;

    mac_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_valid(issue_valid),
        .issue_ready(issue_ready),
        .op_long    (op_long),
        .op_sub     (op_sub),
        .src_a      (src_a),
        .src_b      (src_b),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    int errs = 0;
    int checks = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        bit          lng;
        bit          sub;
        logic [3:0]  md;
        int          cnt;
    } pend_t;

    pend_t       pq[$];
    logic [31:0] m_acc;
    bit          m_known;
    logic [3:0]  m_mode;   // {sat, signed, frac, round}
    logic [2:0]  m_fl;     // {n, z, v}
    int          m_hold;
    bit          m_took;

    function automatic void ref_op(input logic [31:0] acc, input logic [3:0] md,
                                   input bit lng, input bit sub,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [2:0] fl,
                                   output logic [31:0] nacc, output logic [2:0] nfl);
        logic signed [99:0] x, y, p, s, w, lo, hi;
        bit sg, ovf;
        sg = md[2] | md[1];
        if (lng) begin
            x = sg ? {{68{a[31]}}, a} : {68'b0, a};
            y = sg ? {{68{b[31]}}, b} : {68'b0, b};
        end else begin
            x = sg ? {{84{a[15]}}, a[15:0]} : {84'b0, a[15:0]};
            y = sg ? {{84{b[15]}}, b[15:0]} : {84'b0, b[15:0]};
        end
        p = x * y;
        if (md[1]) begin
            p = p * 2;
            if (lng) begin
                if (md[0]) p = p + 100'sd2147483648;
                p = p >>> 32;
            end
        end
        w  = sg ? {{68{acc[31]}}, acc} : {68'b0, acc};
        s  = sub ? (w - p) : (w + p);
        lo = sg ? -100'sd2147483648 : 100'sd0;
        hi = sg ? 100'sd2147483647 : 100'sd4294967295;
        ovf = (s < lo) || (s > hi);
        if (md[3] && s < lo)      nacc = sg ? 32'h8000_0000 : 32'h0;
        else if (md[3] && s > hi) nacc = sg ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
        else                      nacc = s[31:0];
        nfl = {nacc[31], nacc == 32'h0, fl[0] | ovf};
    endfunction

    always @(posedge clk) begin
        logic [3:0]  old_mode;
        logic [31:0] na;
        logic [2:0]  nf;
        pend_t       e;
        if (!rst_n) begin
            pq.delete();
            m_mode = '0; m_fl = '0; m_hold = 0; m_took = 0;
        end else begin
            old_mode = m_mode;
            for (int i = 0; i < pq.size(); i++) pq[i].cnt = pq[i].cnt - 1;
            while (pq.size() > 0 && pq[0].cnt == 0) begin
                ref_op(m_acc, pq[0].md, pq[0].lng, pq[0].sub, pq[0].a, pq[0].b, m_fl, na, nf);
                m_acc = na; m_fl = nf;
                void'(pq.pop_front());
            end
            if (reg_wr) begin
                if (reg_sel) begin m_acc = reg_wdata; m_known = 1; end
                else begin m_mode = reg_wdata[7:4]; m_fl = reg_wdata[3:1]; end
            end
            m_took = 0;
            if (issue_valid && m_hold == 0) begin
                e.a = src_a; e.b = src_b; e.lng = op_long; e.sub = op_sub;
                e.md = old_mode; e.cnt = 2;
                pq.push_back(e);
                m_hold = (op_long ? (old_mode[1] ? 4 : 3) : 1) - 1;
                m_took = 1;
            end else if (m_hold > 0) begin
                m_hold--;
            end
        end
    end

    // Cycle-by-cycle comparison, sampled late in the low phase
    always @(negedge clk) begin
        tog <= ~tog;
        #8;
        if (rst_n === 1'b1) begin
            chk("R2 issue_ready vs model", {31'b0, issue_ready}, {31'b0, m_hold == 0});
            if (!reg_sel) chk("R10 status vs model", reg_rdata, {24'b0, m_mode, m_fl, 1'b0});
            else if (m_known) chk("R3 accumulator vs model", reg_rdata, m_acc);
        end
    end

    // ---------------- stimulus tasks (called just after a falling edge) ----------------
    task automatic write_reg(input bit sel, input logic [31:0] d);
        reg_wr = 1; bforce = 1; bsel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; bforce = 0;
    endtask

    task automatic peek(input bit sel, input string tag, input logic [31:0] exp);
        bforce = 1; bsel = sel;
        #8;
        chk(tag, reg_rdata, exp);
        @(negedge clk);
        bforce = 0;
    endtask

    task automatic peek_ready(input string tag, input bit exp);
        #8;
        chk(tag, {31'b0, issue_ready}, {31'b0, exp});
        @(negedge clk);
    endtask

    task automatic issue_op(input bit lng, input bit sub, input logic [31:0] a, input logic [31:0] b);
        issue_valid = 1; op_long = lng; op_sub = sub; src_a = a; src_b = b;
        forever begin
            @(negedge clk);
            if (m_took) break;
        end
        issue_valid = 0;
    endtask

    task automatic drain();
        repeat (5) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        rst_n = 0; issue_valid = 0; op_long = 0; op_sub = 0; src_a = 0; src_b = 0;
        reg_wr = 0; reg_wdata = 0; tog = 0; bforce = 0; bsel = 0; m_known = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        peek(0, "R1 status after reset", 32'h0);
        peek_ready("R1 ready after reset", 1'b1);

        write_reg(1, 32'hA5A5_0F0F);
        peek(1, "R12 accumulator readback", 32'hA5A5_0F0F);

        // R3 latency
        write_reg(1, 32'h0);
        issue_op(0, 0, 32'd2, 32'd3);
        peek(1, "R3 unchanged one edge after issue", 32'h0);
        peek(1, "R3 unchanged two edges after issue", 32'h0);
        peek(1, "R3 result after third edge", 32'd6);

        // R3/R4 back-to-back unsigned word ops, upper bits ignored
        write_reg(1, 32'h0);
        issue_op(0, 0, 32'h1234_0003, 32'd4);
        issue_op(0, 0, 32'd5, 32'hFFFF_0006);
        issue_op(0, 0, 32'h0000_FFFF, 32'd2);
        drain();
        peek(1, "R3 back-to-back word sum", 32'h0002_0028);

        // R4 signedness
        write_reg(0, 32'h40);
        write_reg(1, 32'h0);
        issue_op(0, 0, 32'h0000_FFFD, 32'd7);
        drain();
        peek(1, "R4 signed word product", 32'hFFFF_FFEB);
        peek(0, "R9 negative flag", 32'h48);
        issue_op(1, 0, 32'hFFFF_FFFE, 32'h0001_0000);
        drain();
        peek(1, "R4 signed long product", 32'hFFFD_FFEB);
        write_reg(0, 32'h0);
        write_reg(1, 32'h0);
        issue_op(0, 0, 32'h0000_FFFD, 32'd7);
        drain();
        peek(1, "R4 unsigned word product", 32'h0006_FFEB);

        // R2 long integer gap
        write_reg(1, 32'h0);
        issue_op(1, 0, 32'h0001_0000, 32'h100);
        peek_ready("R2 long int gap cycle 1", 1'b0);
        peek_ready("R2 long int gap cycle 2", 1'b0);
        peek_ready("R2 long int ready again", 1'b1);
        drain();
        peek(1, "R2 long int product", 32'h0100_0000);

        // R5 fractional, R2 fractional gap
        write_reg(0, 32'h60);
        write_reg(1, 32'h0);
        issue_op(1, 0, 32'h4000_0000, 32'h4000_0000);
        peek_ready("R2 frac gap cycle 1", 1'b0);
        peek_ready("R2 frac gap cycle 2", 1'b0);
        peek_ready("R2 frac gap cycle 3", 1'b0);
        peek_ready("R2 frac ready again", 1'b1);
        drain();
        peek(1, "R5 long fractional product", 32'h2000_0000);
        write_reg(1, 32'h0);
        issue_op(0, 0, 32'h4000, 32'h4000);
        drain();
        peek(1, "R5 word fractional product", 32'h2000_0000);
        write_reg(1, 32'h0);
        issue_op(1, 0, 32'h1, 32'h4000_0000);
        drain();
        peek(1, "R5 truncation drops low half", 32'h0);
        peek(0, "R9 zero flag", 32'h64);

        // R6 rounding
        write_reg(0, 32'h70);
        write_reg(1, 32'h0);
        issue_op(1, 0, 32'h1, 32'h4000_0000);
        drain();
        peek(1, "R6 rounding adds half", 32'h1);

        // R7 saturation
        write_reg(0, 32'hC0);
        write_reg(1, 32'h7FFF_FFF0);
        issue_op(1, 0, 32'h10, 32'h10);
        drain();
        peek(1, "R7 positive clamp", 32'h7FFF_FFFF);
        peek(0, "R7 overflow flag with clamp", 32'hC2);
        write_reg(0, 32'hC0);
        write_reg(1, 32'h8000_0010);
        issue_op(1, 1, 32'h10, 32'h10);
        drain();
        peek(1, "R7 negative clamp", 32'h8000_0000);
        peek(0, "R7 flags after negative clamp", 32'hCA);

        // R11 subtraction
        write_reg(0, 32'h80);
        write_reg(1, 32'd5);
        issue_op(0, 1, 32'd2, 32'd3);
        drain();
        peek(1, "R11 unsigned subtract clamps at zero", 32'h0);
        peek(0, "R11 flags after clamp to zero", 32'h86);
        write_reg(0, 32'h0);
        write_reg(1, 32'd100);
        issue_op(0, 1, 32'd3, 32'd4);
        drain();
        peek(1, "R11 plain subtract", 32'd88);

        // R8 wrap and sticky V
        write_reg(1, 32'hFFFF_FFFF);
        issue_op(0, 0, 32'd1, 32'd1);
        drain();
        peek(1, "R8 wrap to zero", 32'h0);
        peek(0, "R8 overflow and zero flags", 32'h06);
        issue_op(0, 0, 32'd2, 32'd1);
        drain();
        peek(1, "R8 next result", 32'd2);
        peek(0, "R8 overflow stays set", 32'h02);

        // R10 status write masking
        write_reg(0, 32'hFFFF_FFFF);
        peek(0, "R10 reserved bits read zero", 32'hFE);
        write_reg(0, 32'h0);
        peek(0, "R10 write clears flags", 32'h0);

        // Mixed stream checked against the model every cycle
        lf = 32'h1ACE_B00C;
        for (int k = 0; k < 3; k++) begin
            write_reg(0, (k == 0) ? 32'h40 : ((k == 1) ? 32'hC0 : 32'h70));
            write_reg(1, lf ^ 32'h0F0F_0F0F);
            for (int i = 0; i < 20; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                issue_op((i % 3) == 0, (i % 5) == 0, lf, {lf[15:0], lf[31:16]});
            end
            drain();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule